// File: doc/BRIEF.md
# Output Protection and Power-Good Supervisor

This block is the digital supervisor of a synchronous step-down regulator. It takes already-digitised comparator flags for the feedback node, a supply-ready flag, an enable input and a thermal flag. Each of these passes through its own synchronizer. The block times soft-start and the under-voltage blanking window from enable. It confirms over-voltage only after the condition persists, and it latches the over-voltage and under-voltage faults. It issues two gate-override commands to the switching sequencer, and it drives a power-good level with hysteresis and its own deglitch filter.

The state machine has five states. The transitions are named as follows:

- `ST_OFF` goes to `ST_SOFT` (start) when enable is high.
- `ST_SOFT` goes to `ST_RUN` (settle) when the soft-start timer expires.
- `ST_SOFT` or `ST_RUN` goes to `ST_OV_TRIP` (ov_trip) on a confirmed over-voltage.
- `ST_SOFT` or `ST_RUN` goes to `ST_UV_TRIP` (uv_trip) on under-voltage once blanking is over.
- Any state goes to `ST_OFF` (disable) when enable is low.
- Any state goes to `ST_OFF` (power_loss) when the supply is not ready. This transition has the highest priority.

The fault latches are simply the two trip states, so leaving them clears the latch.

Top module: `vreg_guard`

## Requirements
- R1: While supply_ok or enable (after synchronization) is low, the block sits in ST_OFF. In that state gate_off=1, ls_hold=0, pgood=0, ss_active=0, ov_latched=0 and uv_latched=0. This is also the state out of reset.
- R2: After enable is seen, ss_active=1 for SS_CYCLES cycles. During that time pgood stays 0 whatever the level flags say.
- R3: uv_flag has no effect until UV_BLANK_CYCLES cycles after enable was seen, whether the block is in soft-start or in normal running.
- R4: uv_flag after blanking moves the block to ST_UV_TRIP. There uv_latched=1 and gate_off=1, and the state holds after uv_flag clears until enable drops.
- R5: ov_flag acts only after it has been high for OV_CYCLES consecutive synchronized cycles. A shorter pulse leaves ov_latched=0 and ls_hold=0.
- R6: A confirmed over-voltage enters ST_OV_TRIP. There ov_latched=1, ls_hold=1 (low-side on, high-side off) and gate_off=0. It holds after ov_flag clears, ignores uv_flag, and is released only by enable low or supply_ok low.
- R7: In ST_RUN the level window opens when pg_high_flag=1 (output at or above 93%). It closes when pg_low_flag=1 (below 90%) or ov_flag=1. With both level flags at 0 the window keeps its last value.
- R8: pgood changes only after the window result has differed from pgood for PG_CYCLES consecutive cycles, so shorter excursions are ignored. Outside ST_RUN, pgood is forced to 0 at once.
- R9: thermal_flag=1 forces gate_off=1 and ls_hold=0 in every state. It changes no state, and the prior override returns when the flag clears.
- R10: If over-voltage confirmation and a post-blanking under-voltage fall in the same cycle, the over-voltage trip wins.
- R11: A drop of supply_ok clears either fault latch and returns to ST_OFF. When the supply returns with enable high, a fresh soft-start begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above power-on threshold |
| enable | input | 1 | Converter enable |
| ov_flag | input | 1 | Feedback above 125% of reference |
| uv_flag | input | 1 | Feedback below 70% of reference |
| pg_low_flag | input | 1 | Feedback below 90% of reference |
| pg_high_flag | input | 1 | Feedback at or above 93% of reference |
| thermal_flag | input | 1 | Die over temperature |
| gate_off | output | 1 | 1: force both gates low |
| ls_hold | output | 1 | 1: force low-side on, high-side off |
| pgood | output | 1 | 1: release the open-drain power-good line, 0: pull it low |
| ss_active | output | 1 | Soft-start in progress |
| ov_latched | output | 1 | Over-voltage fault latched |
| uv_latched | output | 1 | Under-voltage fault latched |

## Verification
The over-voltage confirmation and the under-voltage trip can fall in the same cycle, because one waits out a persistence counter while the other acts the cycle it is seen. The bench raises ov_flag and then raises uv_flag exactly OV_CYCLES clocks later. Both flags pass through identical synchronizers, so the under-voltage arrives in the very cycle the counter expires. The outcome is judged correct only if ov_latched=1, ls_hold=1 and uv_latched=0. A second overlap is covered as well: a thermal event during an over-voltage latch must take precedence at the gate outputs, and the latch must return once the thermal flag clears.

// File: rtl/vreg_guard_pkg.sv
package vreg_guard_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SOFT    = 3'd1,
        ST_RUN     = 3'd2,
        ST_OV_TRIP = 3'd3,
        ST_UV_TRIP = 3'd4
    } guard_state_e;

    // synchronized flag vector positions
    localparam int FLAG_W   = 7;
    localparam int IDX_SUP  = 0;
    localparam int IDX_EN   = 1;
    localparam int IDX_OV   = 2;
    localparam int IDX_UV   = 3;
    localparam int IDX_PGLO = 4;
    localparam int IDX_PGHI = 5;
    localparam int IDX_HOT  = 6;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[LAST];
    end

endmodule

// File: rtl/persist_timer.sv
module persist_timer #(
    parameter int LEN = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic expired
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!level)      cnt <= '0;
        else if (cnt != TOP)  cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == TOP);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !level |=> cnt == '0);

endmodule

// File: rtl/pgood_filter.sv
module pgood_filter #(
    parameter int HOLD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok,
    input  logic above_hi,
    input  logic below_lo,
    input  logic over_v,
    output logic pgood
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD - 1);

    logic          window_q;
    logic          pg_q;
    logic [CW-1:0] cnt;
    logic          cand;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   window_q <= 1'b0;
        else if (below_lo || over_v)  window_q <= 1'b0;
        else if (above_hi)            window_q <= 1'b1;
    end

    assign cand = run_ok && window_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= 1'b0;
            cnt  <= '0;
        end else if (!run_ok) begin
            pg_q <= 1'b0;
            cnt  <= '0;
        end else if (cand != pg_q) begin
            if (cnt == LIM) begin
                pg_q <= cand;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign pgood = pg_q;

    // R8
    pg_force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !pgood);

    // R8
    pg_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && cand == pg_q) |=> pgood == $past(pg_q));

endmodule

// File: rtl/vreg_guard.sv
module vreg_guard
    import vreg_guard_pkg::*;
#(
    parameter int SS_CYCLES       = 90000,
    parameter int UV_BLANK_CYCLES = 450000,
    parameter int OV_CYCLES       = 500,
    parameter int PG_CYCLES       = 250,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic enable,
    input  logic ov_flag,
    input  logic uv_flag,
    input  logic pg_low_flag,
    input  logic pg_high_flag,
    input  logic thermal_flag,
    output logic gate_off,
    output logic ls_hold,
    output logic pgood,
    output logic ss_active,
    output logic ov_latched,
    output logic uv_latched
);

    logic [FLAG_W-1:0] raw_v, syn_v;
    logic sup_s, en_s, ov_s, uv_s, lo_s, hi_s, hot_s;

    always_comb begin
        raw_v           = '0;
        raw_v[IDX_SUP]  = supply_ok;
        raw_v[IDX_EN]   = enable;
        raw_v[IDX_OV]   = ov_flag;
        raw_v[IDX_UV]   = uv_flag;
        raw_v[IDX_PGLO] = pg_low_flag;
        raw_v[IDX_PGHI] = pg_high_flag;
        raw_v[IDX_HOT]  = thermal_flag;
    end

    flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_v),
        .q_sync  (syn_v)
    );

    assign sup_s = syn_v[IDX_SUP];
    assign en_s  = syn_v[IDX_EN];
    assign ov_s  = syn_v[IDX_OV];
    assign uv_s  = syn_v[IDX_UV];
    assign lo_s  = syn_v[IDX_PGLO];
    assign hi_s  = syn_v[IDX_PGHI];
    assign hot_s = syn_v[IDX_HOT];

    guard_state_e state_q, state_d;
    logic active, ss_done, blank_done, ov_hit, run_ok;

    assign active = (state_q == ST_SOFT) || (state_q == ST_RUN);
    assign run_ok = (state_q == ST_RUN);

    persist_timer #(.LEN(SS_CYCLES)) u_ss_tmr (
        .clk (clk), .rst_n (rst_n), .level (active), .expired (ss_done)
    );

    persist_timer #(.LEN(UV_BLANK_CYCLES)) u_blank_tmr (
        .clk (clk), .rst_n (rst_n), .level (active), .expired (blank_done)
    );

    persist_timer #(.LEN(OV_CYCLES)) u_ov_tmr (
        .clk (clk), .rst_n (rst_n), .level (active && ov_s), .expired (ov_hit)
    );

    pgood_filter #(.HOLD(PG_CYCLES)) u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_ok   (run_ok),
        .above_hi (hi_s),
        .below_lo (lo_s),
        .over_v   (ov_s),
        .pgood    (pgood)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!sup_s) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (en_s) state_d = ST_SOFT;
                end
                ST_SOFT: begin
                    if (!en_s)                    state_d = ST_OFF;
                    else if (ov_hit)              state_d = ST_OV_TRIP;
                    else if (uv_s && blank_done)  state_d = ST_UV_TRIP;
                    else if (ss_done)             state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!en_s)                    state_d = ST_OFF;
                    else if (ov_hit)              state_d = ST_OV_TRIP;
                    else if (uv_s && blank_done)  state_d = ST_UV_TRIP;
                end
                ST_OV_TRIP, ST_UV_TRIP: begin
                    if (!en_s) state_d = ST_OFF;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        gate_off   = 1'b0;
        ls_hold    = 1'b0;
        ss_active  = 1'b0;
        ov_latched = 1'b0;
        uv_latched = 1'b0;
        unique case (state_q)
            ST_OFF:     gate_off = 1'b1;
            ST_SOFT:    ss_active = 1'b1;
            ST_RUN:     ;
            ST_OV_TRIP: begin
                ls_hold    = 1'b1;
                ov_latched = 1'b1;
            end
            ST_UV_TRIP: begin
                gate_off   = 1'b1;
                uv_latched = 1'b1;
            end
            default:    gate_off = 1'b1;
        endcase
        if (hot_s) begin
            gate_off = 1'b1;
            ls_hold  = 1'b0;
        end
    end

    // R1
    off_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> state_q == ST_OFF);

    // R2
    soft_pg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SOFT |-> !pgood);

    // R3
    uv_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !blank_done) |=> state_q != ST_UV_TRIP);

    // R5
    ov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_OV_TRIP) |-> $past(ov_hit));

    // R6
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OV_TRIP && en_s && sup_s) |=> state_q == ST_OV_TRIP);

    // R10
    ov_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && en_s && sup_s && ov_hit && uv_s && blank_done)
            |=> state_q == ST_OV_TRIP);

endmodule

// File: tb/test_vreg_guard.sv
module test_vreg_guard;

    localparam int SS  = 200;
    localparam int BLK = 600;
    localparam int OVC = 40;
    localparam int PGC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, enable = 1'b0;
    logic ov_flag = 1'b0, uv_flag = 1'b0, pg_low_flag = 1'b0;
    logic pg_high_flag = 1'b0, thermal_flag = 1'b0;
    logic gate_off, ls_hold, pgood, ss_active, ov_latched, uv_latched;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vreg_guard #(
        .SS_CYCLES(SS), .UV_BLANK_CYCLES(BLK), .OV_CYCLES(OVC), .PG_CYCLES(PGC)
    ) i_vreg_guard (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .pg_low_flag(pg_low_flag),
        .pg_high_flag(pg_high_flag), .thermal_flag(thermal_flag),
        .gate_off(gate_off), .ls_hold(ls_hold), .pgood(pgood),
        .ss_active(ss_active), .ov_latched(ov_latched), .uv_latched(uv_latched)
    );

    typedef struct packed {
        logic       ov, uv, lo, hi, hot;
        logic [15:0] wt;
        logic       g, l, p, s, o, u;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        //ov  uv  lo  hi  hot  wait    goff ls  pg  ss  ovl uvl  req
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd100,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd3}, // R2 R3 in soft-start
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd200,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd7}, // R7 rise after soft-start
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'd50, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd3}, // R3 blanked in run
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'd50, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd7}, // R7 hysteresis hold high
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd50, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd7}, // R7 below 90%
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'd50, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd7}, // R7 hysteresis hold low
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd50, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd7}, // R7 back above 93%
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'd8,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd8}, // R8 short dip ignored
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd40, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd8}, // R8 stays high
        '{1'b0,1'b0,1'b0,1'b1,1'b1,16'd6,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'd9}, // R9 thermal on
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd6,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd9}, // R9 thermal released
        '{1'b1,1'b0,1'b0,1'b1,1'b0,16'd15, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd5}, // R5 short OV pulse
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd40, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd5}, // R5 no latch
        '{1'b1,1'b0,1'b0,1'b1,1'b0,16'd60, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'd6}, // R6 OV latched
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'd20, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'd6}, // R6 holds, UV ignored
        '{1'b0,1'b1,1'b0,1'b1,1'b1,16'd6,  1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'd9}, // R9 over OV latch
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd6,  1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'd9}  // R9 latch returns
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic g, input logic l, input logic p,
                           input logic s, input logic o, input logic u);
        chk({req, " gate_off"},   gate_off,   g);
        chk({req, " ls_hold"},    ls_hold,    l);
        chk({req, " pgood"},      pgood,      p);
        chk({req, " ss_active"},  ss_active,  s);
        chk({req, " ov_latched"}, ov_latched, o);
        chk({req, " uv_latched"}, uv_latched, u);
    endtask

    task automatic clear_flags();
        ov_flag = 1'b0; uv_flag = 1'b0; pg_low_flag = 1'b0;
        pg_high_flag = 1'b0; thermal_flag = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(5);
        // R1 reset / off state
        chk_all("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        supply_ok = 1'b1;
        step(10);
        chk_all("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            ov_flag      = VECS[i].ov;
            uv_flag      = VECS[i].uv;
            pg_low_flag  = VECS[i].lo;
            pg_high_flag = VECS[i].hi;
            thermal_flag = VECS[i].hot;
            step(int'(VECS[i].wt));
            chk_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                    VECS[i].g, VECS[i].l, VECS[i].p, VECS[i].s, VECS[i].o, VECS[i].u);
        end

        // R6 release by enable low, R1 off outputs
        clear_flags();
        enable = 1'b0;
        step(6);
        chk_all("R6 release", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R4 under-voltage after blanking
        enable = 1'b1;
        pg_high_flag = 1'b1;
        step(BLK + 100);
        uv_flag = 1'b1;
        step(6);
        chk("R4 uv_latched", uv_latched, 1'b1);
        chk("R4 gate_off", gate_off, 1'b1);
        chk("R4 pgood", pgood, 1'b0);
        uv_flag = 1'b0;
        step(20);
        chk("R4 held uv_latched", uv_latched, 1'b1);
        chk("R4 held gate_off", gate_off, 1'b1);
        enable = 1'b0;
        step(6);
        chk("R4 cleared uv_latched", uv_latched, 1'b0);

        // R10 OV confirmation and UV in the same cycle
        enable = 1'b1;
        step(BLK + 100);
        chk("R10 pre pgood", pgood, 1'b1);
        ov_flag = 1'b1;
        step(OVC);
        uv_flag = 1'b1;
        step(10);
        chk("R10 ov_latched", ov_latched, 1'b1);
        chk("R10 uv_latched", uv_latched, 1'b0);
        chk("R10 ls_hold", ls_hold, 1'b1);
        clear_flags();

        // R11 supply loss clears latch, supply return restarts soft-start
        supply_ok = 1'b0;
        step(6);
        chk_all("R11 loss", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        supply_ok = 1'b1;
        step(6);
        chk("R11 restart ss_active", ss_active, 1'b1);
        chk("R11 restart gate_off", gate_off, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule